// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

The block judges every load, store and instruction fetch issued by a processor against eight programmable memory regions. Each region holds a base address, a power-of-two size, an enable, a write permission, an execute permission and a kernel-only flag. Privileged software fills these descriptors through a single-cycle configuration port, for instance when it switches threads.

The verdict is combinational. In the same cycle as the request, the checker raises either a grant or a fault pulse. The first fault is then captured in sticky status registers that hold the faulting address and a cause code. The fault line can drive a memory-management exception, and its handler reads the captured state and clears it. When no enabled region covers an address, privileged code may still use that address, but an unprivileged thread may not.

The asynchronous active-low reset is released into the logic through a two-stage synchronizer. Internal state therefore leaves reset on the second rising clock edge after `rst_n` rises.

Top module: `mem_guard`

## Requirements
- R1: While reset is held, and after reset until a region is configured, every region is disabled and `flt_valid` is 0.
- R2: A region with size code S covers the addresses whose bits at positions S and above equal those bits of its base. The low bits of the base are ignored. S below 5 is treated as 5, and S above 32 is treated as 32, which covers the whole address space. A disabled region covers nothing.
- R3: When several enabled regions cover an address, only the attributes of the highest-numbered covering region are used.
- R4: Access type codes are 0 for read, 1 for write and 2 for execute, and code 3 is treated as a read. In a covering region without write permission, a write faults with cause 1 and a read is granted.
- R5: In a covering region without execute permission, a fetch (type 2) faults with cause 2.
- R6: In a covering kernel-only region, any unprivileged access faults with cause 3. This check takes precedence over the write and execute checks. A privileged access to such a region is checked only against the write and execute permissions.
- R7: When no enabled region covers the address, a privileged access is granted. An unprivileged access faults with a cause equal to its type code: 0 for read, 1 for write, 2 for execute.
- R8: While `acc_valid` is 1, exactly one of `acc_grant` and `acc_fault` is 1 in the same cycle. While `acc_valid` is 0, both are 0 and nothing is captured.
- R9: A fault seen at a clock edge while `flt_valid` is 0 sets `flt_valid` and latches `flt_addr` and `flt_cause`. While `flt_valid` is 1, later faults do not change the captured values.
- R10: `flt_clear` clears `flt_valid` at the next edge. If a fault is present in that same cycle, the new fault is captured instead.
- R11: A configuration write replaces the whole descriptor of region `cfg_idx` at the next edge and leaves the other regions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one region descriptor |
| cfg_idx | input | 3 | Region number to write |
| cfg_base | input | 32 | Region base address |
| cfg_size_log2 | input | 6 | Region size as a power of two |
| cfg_enable | input | 1 | Region enable |
| cfg_writable | input | 1 | Writes allowed |
| cfg_exec | input | 1 | Fetches allowed |
| cfg_kernel | input | 1 | Region reachable only when privileged |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| acc_priv | input | 1 | Access is privileged |
| acc_grant | output | 1 | Access allowed |
| acc_fault | output | 1 | Access violates protection (fault pulse) |
| flt_clear | input | 1 | Clear the sticky fault status |
| flt_valid | output | 1 | A fault has been captured |
| flt_addr | output | 32 | Captured faulting address |
| flt_cause | output | 2 | Captured cause: 0 read, 1 write, 2 execute, 3 privilege |

## Verification
The tests first probe the unconfigured checker with privileged and unprivileged accesses of each type. This shows the background rule apart from region matching. Addresses are then placed just inside and just outside regions of several sizes, including a size code below the minimum and one above the address width, to expose errors in the mask and the clamping. Overlapping regions, with stricter and looser attributes at higher indices, separate priority selection from the individual permission checks. Back-to-back faults, clears and a clear that coincides with a fault test the sticky capture. Every cycle is compared against a behavioural model.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef enum logic [1:0] {
    CAUSE_READ  = 2'd0,
    CAUSE_WRITE = 2'd1,
    CAUSE_EXEC  = 2'd2,
    CAUSE_PRIV  = 2'd3
  } mg_cause_e;

  typedef struct packed {
    logic wr;
    logic ex;
    logic kr;
  } mg_attr_t;
endpackage

// File: rtl/mg_rst_sync.sv
module mg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/mg_region.sv
module mg_region
  import mg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SZ_W     = 6,
  parameter int IDX_W    = 3,
  parameter int IDX      = 0,
  parameter int MIN_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic              cfg_en,
  input  mg_attr_t          cfg_attr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit,
  output mg_attr_t          attr
);
  logic              en_q, en_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [SZ_W-1:0]   size_q, size_d;
  mg_attr_t          attr_q, attr_d;
  logic              wr_en;
  logic [SZ_W-1:0]   sz_eff;
  logic [ADDR_W-1:0] mask;

  assign wr_en = cfg_we && (cfg_idx == IDX_W'(IDX));

  always_comb begin
    en_d   = wr_en ? cfg_en   : en_q;
    base_d = wr_en ? cfg_base : base_q;
    size_d = wr_en ? cfg_size : size_q;
    attr_d = wr_en ? cfg_attr : attr_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      size_q <= '0;
      attr_q <= '0;
    end else begin
      en_q   <= en_d;
      base_q <= base_d;
      size_q <= size_d;
      attr_q <= attr_d;
    end
  end

  always_comb begin
    if (size_q < SZ_W'(MIN_LOG2))   sz_eff = SZ_W'(MIN_LOG2);
    else if (size_q > SZ_W'(ADDR_W)) sz_eff = SZ_W'(ADDR_W);
    else                             sz_eff = size_q;
    for (int i = 0; i < ADDR_W; i++) mask[i] = (SZ_W'(i) >= sz_eff);
  end

  assign hit  = en_q && (((acc_addr ^ base_q) & mask) == '0);
  assign attr = attr_q;

  // R11: a region not addressed by a write keeps its descriptor
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> ($stable(attr_q) && $stable(base_q) && $stable(en_q) && $stable(size_q)));
endmodule

// File: rtl/mg_arbiter.sv
module mg_arbiter
  import mg_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic       [N-1:0] hit,
  input  mg_attr_t   [N-1:0] attr,
  input  logic               acc_valid,
  input  logic [1:0]         acc_type,
  input  logic               acc_priv,
  output logic               grant,
  output logic               fault,
  output logic [1:0]         cause
);
  logic             found;
  logic [IDX_W-1:0] sel;
  mg_attr_t         win;
  logic             ok;
  mg_cause_e        why;
  mg_cause_e        type_cause;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
    win = attr[sel];
  end

  always_comb begin
    case (acc_type)
      ACC_WRITE: type_cause = CAUSE_WRITE;
      ACC_EXEC:  type_cause = CAUSE_EXEC;
      default:   type_cause = CAUSE_READ;
    endcase
    ok  = 1'b1;
    why = type_cause;
    if (!found) begin
      ok = acc_priv;
    end else if (win.kr && !acc_priv) begin
      ok  = 1'b0;
      why = CAUSE_PRIV;
    end else if (acc_type == ACC_WRITE && !win.wr) begin
      ok = 1'b0;
    end else if (acc_type == ACC_EXEC && !win.ex) begin
      ok = 1'b0;
    end
  end

  assign grant = acc_valid && ok;
  assign fault = acc_valid && !ok;
  assign cause = why;
endmodule

// File: rtl/mg_fault_capture.sv
module mg_fault_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              fault,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cause,
  input  logic              clear,
  output logic              valid_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        cause_q
);
  logic              cap_en;
  logic              valid_d;
  logic [ADDR_W-1:0] addr_d;
  logic [1:0]        cause_d;

  assign cap_en = fault && (!valid_q || clear);

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    cause_d = cause_q;
    if (cap_en) begin
      valid_d = 1'b1;
      addr_d  = addr;
      cause_d = cause;
    end else if (clear) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      cause_q <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      cause_q <= cause_d;
    end
  end

  // R9: first fault is latched with its address and cause
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    (fault && (!valid_q || clear)) |=> (valid_q && addr_q == $past(addr) && cause_q == $past(cause)));
  // R9: captured state is held while sticky
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_q && !clear) |=> (valid_q && $stable(addr_q) && $stable(cause_q)));
  // R10: clear without a new fault empties the status
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear && !fault) |=> !valid_q);
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int MIN_LOG2    = 5,
  localparam int IDX_W      = $clog2(NUM_REGIONS),
  localparam int SZ_W       = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size_log2,
  input  logic              cfg_enable,
  input  logic              cfg_writable,
  input  logic              cfg_exec,
  input  logic              cfg_kernel,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_type,
  input  logic              acc_priv,
  output logic              acc_grant,
  output logic              acc_fault,
  input  logic              flt_clear,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [1:0]        flt_cause
);
  logic                         rst_ni;
  logic     [NUM_REGIONS-1:0]   hit;
  mg_attr_t [NUM_REGIONS-1:0]   attr;
  mg_attr_t                     cfg_attr;
  logic     [1:0]               cause;

  assign cfg_attr = '{wr: cfg_writable, ex: cfg_exec, kr: cfg_kernel};

  mg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_ni)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    mg_region #(
      .ADDR_W(ADDR_W), .SZ_W(SZ_W), .IDX_W(IDX_W), .IDX(g), .MIN_LOG2(MIN_LOG2)
    ) u_region (
      .clk(clk), .rst_ni(rst_ni), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_base(cfg_base), .cfg_size(cfg_size_log2), .cfg_en(cfg_enable),
      .cfg_attr(cfg_attr), .acc_addr(acc_addr), .hit(hit[g]), .attr(attr[g])
    );
  end

  mg_arbiter #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_arb (
    .hit(hit), .attr(attr), .acc_valid(acc_valid), .acc_type(acc_type),
    .acc_priv(acc_priv), .grant(acc_grant), .fault(acc_fault), .cause(cause)
  );

  mg_fault_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_ni(rst_ni), .fault(acc_fault), .addr(acc_addr),
    .cause(cause), .clear(flt_clear), .valid_q(flt_valid),
    .addr_q(flt_addr), .cause_q(flt_cause)
  );

  // R8: one verdict per valid request, none otherwise
  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_valid |-> (acc_grant != acc_fault));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !acc_valid |-> (!acc_grant && !acc_fault));
  // R7: privileged access outside every region is allowed
  a_r7_background: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_valid && acc_priv && hit == '0) |-> acc_grant);
endmodule

// File: tb/tb_mem_guard.sv
module tb_mem_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_base;
  logic [5:0]  cfg_size_log2;
  logic        cfg_enable, cfg_writable, cfg_exec, cfg_kernel;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_type;
  logic        acc_priv;
  logic        acc_grant, acc_fault;
  logic        flt_clear;
  logic        flt_valid;
  logic [31:0] flt_addr;
  logic [1:0]  flt_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2), .cfg_enable(cfg_enable),
    .cfg_writable(cfg_writable), .cfg_exec(cfg_exec), .cfg_kernel(cfg_kernel),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type),
    .acc_priv(acc_priv), .acc_grant(acc_grant), .acc_fault(acc_fault),
    .flt_clear(flt_clear), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_cause(flt_cause)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit          m_en [8];
  bit          m_wr [8];
  bit          m_ex [8];
  bit          m_kr [8];
  logic [31:0] m_base [8];
  int          m_sz [8];
  bit          m_fv;
  logic [31:0] m_fa;
  int          m_fc;
  int          m_sync;

  task automatic verdict(output bit ok, output int why);
    int sel = -1;
    for (int i = 0; i < 8; i++) begin
      int s = m_sz[i];
      if (s < 5) s = 5;
      if (s > 32) s = 32;
      if (m_en[i] && ((acc_addr >> s) == (m_base[i] >> s))) sel = i;
    end
    why = (acc_type == 2'd1) ? 1 : (acc_type == 2'd2) ? 2 : 0;
    ok = 1;
    if (sel < 0) ok = acc_priv;
    else if (m_kr[sel] && !acc_priv) begin ok = 0; why = 3; end
    else if (acc_type == 2'd1 && !m_wr[sel]) ok = 0;
    else if (acc_type == 2'd2 && !m_ex[sel]) ok = 0;
  endtask

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    bit ok; int why; bit f;
    #1;
    verdict(ok, why);
    chk(tag, "grant", acc_grant, acc_valid && ok);
    chk(tag, "fault", acc_fault, acc_valid && !ok);
    chk(tag, "flt_valid", flt_valid, m_fv);
    if (m_fv) begin
      chk(tag, "flt_addr", flt_addr, m_fa);
      chk(tag, "flt_cause", flt_cause, m_fc);
    end
    @(posedge clk);
    if (!rst_n) m_sync = 0;
    else if (m_sync < 2) m_sync++;
    else begin
      f = acc_valid && !ok;
      if (cfg_we) begin
        m_en[cfg_idx] = cfg_enable; m_wr[cfg_idx] = cfg_writable;
        m_ex[cfg_idx] = cfg_exec;   m_kr[cfg_idx] = cfg_kernel;
        m_base[cfg_idx] = cfg_base; m_sz[cfg_idx] = cfg_size_log2;
      end
      if (f && (!m_fv || flt_clear)) begin
        m_fv = 1; m_fa = acc_addr; m_fc = why;
      end else if (flt_clear) m_fv = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 0; acc_valid = 0; flt_clear = 0;
  endtask

  task automatic cfg(input int idx, input logic [31:0] base, input int sz,
                     input bit en, input bit wr, input bit ex, input bit kr, input string tag);
    idle();
    cfg_we = 1; cfg_idx = 3'(idx); cfg_base = base; cfg_size_log2 = 6'(sz);
    cfg_enable = en; cfg_writable = wr; cfg_exec = ex; cfg_kernel = kr;
    cycle(tag);
    idle();
  endtask

  task automatic acc(input logic [31:0] a, input int t, input bit p, input bit clr,
                     input bit v, input string tag);
    idle();
    acc_valid = v; acc_addr = a; acc_type = 2'(t); acc_priv = p; flt_clear = clr;
    cycle(tag);
    idle();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_en[i] = 0; m_wr[i] = 0; m_ex[i] = 0; m_kr[i] = 0; m_base[i] = 0; m_sz[i] = 0;
    end
    m_fv = 0; m_fa = 0; m_fc = 0; m_sync = 0;
    rst_n = 0; idle();
    cfg_idx = 0; cfg_base = 0; cfg_size_log2 = 0;
    cfg_enable = 0; cfg_writable = 0; cfg_exec = 0; cfg_kernel = 0;
    acc_addr = 0; acc_type = 0; acc_priv = 0;
    @(negedge clk);
    cycle("R1");
    cycle("R1");
    rst_n = 1;
    for (int i = 0; i < 3; i++) cycle("R1");
    // R7 background with no regions configured
    acc(32'h0000_1000, 0, 0, 0, 1, "R7");
    acc(32'h0000_1000, 1, 1, 0, 1, "R7");
    acc(32'h0000_2000, 2, 0, 0, 1, "R9");
    acc(32'h0000_2000, 1, 0, 0, 1, "R9");
    acc(32'h0000_0000, 0, 0, 1, 0, "R10");
    acc(32'h0000_3000, 2, 1, 0, 1, "R7");
    // R8: no request, no verdict, no capture
    acc(32'h0000_3000, 1, 0, 0, 0, "R8");
    cycle("R8");
    // R11 / R2: region 0 = 64 KiB at 0, full access
    cfg(0, 32'h0000_0000, 16, 1, 1, 1, 0, "R11");
    acc(32'h0000_1234, 0, 0, 0, 1, "R2");
    acc(32'h0000_1234, 1, 0, 0, 1, "R2");
    acc(32'h0000_FFFF, 2, 0, 0, 1, "R2");
    acc(32'h0001_0000, 3, 0, 0, 1, "R2");
    acc(32'h0, 0, 0, 1, 0, "R10");
    // region 1: 4 KiB read-only, no execute, overlapping region 0
    cfg(1, 32'h0000_4000, 12, 1, 0, 0, 0, "R11");
    acc(32'h0000_4010, 1, 0, 0, 1, "R4");
    acc(32'h0, 0, 0, 1, 0, "R10");
    acc(32'h0000_4010, 0, 0, 0, 1, "R4");
    acc(32'h0000_4010, 3, 0, 0, 1, "R4");
    acc(32'h0000_4FFC, 2, 0, 0, 1, "R5");
    acc(32'h0, 0, 0, 1, 0, "R10");
    acc(32'h0000_5000, 1, 0, 0, 1, "R3");
    acc(32'h0000_3FFF, 2, 0, 0, 1, "R3");
    // region 2: size code 3 clamps to 32 bytes, kernel only
    cfg(2, 32'h8000_0123, 3, 1, 1, 0, 1, "R11");
    acc(32'h8000_0130, 0, 0, 0, 1, "R6");
    acc(32'h0, 0, 0, 1, 0, "R10");
    acc(32'h8000_0130, 1, 0, 0, 1, "R6");
    acc(32'h0, 0, 0, 1, 0, "R10");
    acc(32'h8000_013F, 1, 1, 0, 1, "R6");
    acc(32'h8000_013F, 2, 1, 0, 1, "R6");
    acc(32'h0, 0, 0, 1, 0, "R10");
    acc(32'h8000_011F, 0, 0, 0, 1, "R2");
    acc(32'h0, 0, 0, 1, 0, "R10");
    acc(32'h8000_0140, 0, 1, 0, 1, "R2");
    // region 7: size code 40 covers everything, read-only
    cfg(7, 32'h1234_5678, 40, 1, 0, 0, 0, "R11");
    acc(32'h0000_1234, 1, 1, 0, 1, "R3");
    acc(32'h0, 0, 0, 1, 0, "R10");
    acc(32'hFFFF_FFF0, 0, 0, 0, 1, "R3");
    acc(32'h8000_0130, 0, 0, 0, 1, "R3");
    // disabling region 7 restores lower regions
    cfg(7, 32'h0, 40, 0, 0, 0, 0, "R11");
    acc(32'h0000_1234, 1, 1, 0, 1, "R2");
    acc(32'h0000_4010, 1, 1, 0, 1, "R4");
    // R10: clear in the same cycle as a new fault captures the new one
    acc(32'h0000_4020, 2, 0, 1, 1, "R10");
    acc(32'h0000_4040, 1, 0, 0, 1, "R9");
    acc(32'h0, 0, 0, 1, 0, "R10");
    cycle("R10");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule